// File: doc/BRIEF.md
# One-Time-Programmable Fuse Word Reader

This block holds a small fuse array of 16-bit words and lets software fetch one word at a time through a simple register bus. The bus slave has no wait states and reads back through a combinational path. Software first raises the external enable input and waits for the idle flag in the status register. It then writes a word number into the index register and pulses the read command in the command register. After that it polls until the completion flag is set, takes the word from the data register, and finally writes the acknowledge command to drop the flag.

The length of each read, in clock cycles, comes from a timing register. The burn command is only modelled: it keeps a busy flag high for a programmable number of cycles and never changes the array. A protection input, strapped at reset, blocks that command. The array contents are generated from a seed parameter.

Top module: `fuse_read_ctrl`

## Requirements
- R1: After reset the read-timing register (offset 0x24) reads 4, the write-timing register (0x20) reads 8, and every other register reads 0. The idle flag (status bit 2) is 1 only while the enable input is high.
- R2: The index register (0x0C) keeps only bits [4:0] of a written value and reads back zero in its upper bits.
- R3: A write of bit 1 to the command register (0x10) starts a read only when the enable input is high and the block is idle. Otherwise the command has no effect, and this includes a command issued during a read that is already in progress.
- R4: An accepted read keeps status bit 1 high and status bit 2 low for max(T,1) cycles, where T is bits [7:0] of 0x24 at the start. In the cycle that bit 1 falls, the completion flag (status bit 4) is set.
- R5: When a read completes, the data register (0x04) holds, in bits [15:0], the fuse word at the index captured at the start, and zero above. Word i equals 16'hC3A5 XOR (i * 16'h0811), truncated to 16 bits.
- R6: The completion flag stays set when the data register is read. Only a write of bit 2 to 0x10 clears it, and if that clear coincides with a read finishing, the flag ends set.
- R7: A write of bit 0 to 0x10, accepted under the same conditions as a read, keeps status bit 0 high and bit 2 low for max(W,1) cycles, where W is bits [7:0] of 0x20. It leaves the array unchanged. It is ignored while the protect input is high, and it is ignored whenever bit 1 is written in the same access (the read runs instead).
- R8: The status register (0x14) bits are: [0] burn busy, [1] read busy, [2] idle, [3] protect input, [4] completion. All other bits read 0, and the two busy bits are never high together.
- R9: Reads of offsets that are not in the register set, or that are not word aligned, return 0. Writes to them change nothing.
- R10: A read or burn that is under way runs to completion even if the enable input falls. While the enable input is low the idle flag reads 0.
- R11: Writes to the status register have no effect, and the command register always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mod_en | input | 1 | Module enable from the global enable register |
| prot_strap | input | 1 | Protection strap that blocks the burn command |
| bus_addr | input | 6 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The bench aims at the cycle in which a read finishes. A design with an off-by-one read length would show the busy bit for one cycle too many or too few. One that raised the flag a cycle after busy fell would show a gap in the status trace. A clear written in that same cycle must lose, and a design that let the clear win would drop the flag so that software missed the word. A second read command issued mid-read must not restart the counter or change the captured index; a design that accepted it would return the wrong word late. The bench also checks that the protect strap, a zero timing value and a dual command in one write are each handled as the requirements state. It confirms that a drop of the enable input does not abort a read in progress, and that the index, status and hole offsets ignore the bits and writes they should.

// File: rtl/fuse_ctrl_pkg.sv
// Shared constants and types for the fuse word reader.
// Assumes byte offsets fit in the bus address width chosen by the top.
package fuse_ctrl_pkg;

    // register byte offsets; software depends on these
    localparam int OFS_GLB    = 'h00;
    localparam int OFS_RDATA  = 'h04;
    localparam int OFS_WDATA  = 'h08;
    localparam int OFS_INDEX  = 'h0C;
    localparam int OFS_CMD    = 'h10;
    localparam int OFS_STATUS = 'h14;
    localparam int OFS_WTIME  = 'h20;
    localparam int OFS_RTIME  = 'h24;
    localparam int OFS_DEBNC  = 'h28;

    // status bit positions
    localparam int ST_PG   = 0;
    localparam int ST_RD   = 1;
    localparam int ST_IDLE = 2;
    localparam int ST_PROT = 3;
    localparam int ST_DONE = 4;

    // command strobe bit positions
    localparam int CMD_PG  = 0;
    localparam int CMD_RD  = 1;
    localparam int CMD_CLR = 2;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_READ = 2'd1,
        OP_PROG = 2'd2
    } op_e;

    // content of fuse word idx, derived from a seed
    function automatic logic [31:0] fuse_pattern(input logic [31:0] seed,
                                                 input int unsigned idx);
        return seed ^ (32'(idx) * 32'h0000_0811);
    endfunction

endpackage

// File: rtl/fuse_rom.sv
// Behavioural fuse array: N_BLK constant words of FUSE_W bits.
// The contents are computed from SEED at elaboration. The word
// selected by sel is presented combinationally.
module fuse_rom
    import fuse_ctrl_pkg::*;
#(
    parameter int          N_BLK  = 32,
    parameter int          FUSE_W = 16,
    parameter int          IDX_W  = $clog2(N_BLK),
    parameter logic [31:0] SEED   = 32'h0000_C3A5
) (
    input  logic [IDX_W-1:0]  sel,
    output logic [FUSE_W-1:0] word
);

    logic [FUSE_W-1:0] rom [N_BLK];

    // one constant word per fuse block
    for (genvar g = 0; g < N_BLK; g++) begin : g_blk
        assign rom[g] = FUSE_W'(fuse_pattern(SEED, g));
    end

    // word selection
    assign word = rom[sel];

endmodule

// File: rtl/fuse_regs.sv
// Register bus slave: decodes single-cycle writes, holds the software
// registers, turns command writes into one-cycle strobes and builds the
// combinational read mux. Assumes one access per cycle and byte offsets
// that are word aligned; any other offset reads as zero.
module fuse_regs
    import fuse_ctrl_pkg::*;
#(
    parameter int AW         = 6,
    parameter int DATA_W     = 32,
    parameter int FUSE_W     = 16,
    parameter int IDX_W      = 5,
    parameter int TIM_W      = 8,
    parameter int RD_TIM_RST = 4,
    parameter int WR_TIM_RST = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              st_pg_busy,
    input  logic              st_rd_busy,
    input  logic              st_idle,
    input  logic              st_prot,
    input  logic              st_done,
    input  logic [FUSE_W-1:0] rd_word,
    output logic [IDX_W-1:0]  blk_idx,
    output logic [TIM_W-1:0]  rd_tim,
    output logic [TIM_W-1:0]  wr_tim,
    output logic              cmd_rd,
    output logic              cmd_pg,
    output logic              cmd_clr
);

    logic [FUSE_W-1:0] glb_q;
    logic [FUSE_W-1:0] wdat_q;
    logic [FUSE_W-1:0] deb_q;
    logic              wr_glb, wr_wdat, wr_idx, wr_cmd, wr_wt, wr_rt, wr_deb;
    logic              unused_wdata;

    // address decode of write accesses
    assign wr_glb  = bus_wr && (bus_addr == AW'(OFS_GLB));
    assign wr_wdat = bus_wr && (bus_addr == AW'(OFS_WDATA));
    assign wr_idx  = bus_wr && (bus_addr == AW'(OFS_INDEX));
    assign wr_cmd  = bus_wr && (bus_addr == AW'(OFS_CMD));
    assign wr_wt   = bus_wr && (bus_addr == AW'(OFS_WTIME));
    assign wr_rt   = bus_wr && (bus_addr == AW'(OFS_RTIME));
    assign wr_deb  = bus_wr && (bus_addr == AW'(OFS_DEBNC));

    // command strobes live only for the write cycle
    assign cmd_rd  = wr_cmd && bus_wdata[CMD_RD];
    assign cmd_pg  = wr_cmd && bus_wdata[CMD_PG];
    assign cmd_clr = wr_cmd && bus_wdata[CMD_CLR];

    assign unused_wdata = ^bus_wdata[DATA_W-1:FUSE_W];

    // plain storage registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_q  <= '0;
            wdat_q <= '0;
            deb_q  <= '0;
        end else begin
            if (wr_glb)  glb_q  <= bus_wdata[FUSE_W-1:0];
            if (wr_wdat) wdat_q <= bus_wdata[FUSE_W-1:0];
            if (wr_deb)  deb_q  <= bus_wdata[FUSE_W-1:0];
        end
    end

    // block index keeps only its low IDX_W bits
    always_ff @(posedge clk) begin
        if (!rst_n)      blk_idx <= '0;
        else if (wr_idx) blk_idx <= bus_wdata[IDX_W-1:0];
    end

    // timing registers with non-zero reset defaults
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_tim <= TIM_W'(RD_TIM_RST);
            wr_tim <= TIM_W'(WR_TIM_RST);
        end else begin
            if (wr_rt) rd_tim <= bus_wdata[TIM_W-1:0];
            if (wr_wt) wr_tim <= bus_wdata[TIM_W-1:0];
        end
    end

    // combinational read mux; holes, command and unaligned offsets give zero
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(OFS_GLB):    bus_rdata = DATA_W'(glb_q);
            AW'(OFS_RDATA):  bus_rdata = DATA_W'(rd_word);
            AW'(OFS_WDATA):  bus_rdata = DATA_W'(wdat_q);
            AW'(OFS_INDEX):  bus_rdata = DATA_W'(blk_idx);
            AW'(OFS_WTIME):  bus_rdata = DATA_W'(wr_tim);
            AW'(OFS_RTIME):  bus_rdata = DATA_W'(rd_tim);
            AW'(OFS_DEBNC):  bus_rdata = DATA_W'(deb_q);
            AW'(OFS_STATUS): begin
                bus_rdata[ST_PG]   = st_pg_busy;
                bus_rdata[ST_RD]   = st_rd_busy;
                bus_rdata[ST_IDLE] = st_idle;
                bus_rdata[ST_PROT] = st_prot;
                bus_rdata[ST_DONE] = st_done;
            end
            default:         bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/fuse_seq.sv
// Operation sequencer: accepts read and burn commands while enabled and
// idle, counts the programmed duration, captures the fuse word at the end
// of a read and keeps the sticky completion flag. One shared down-counter
// serves both operations because only one can run at a time.
module fuse_seq
    import fuse_ctrl_pkg::*;
#(
    parameter int FUSE_W = 16,
    parameter int IDX_W  = 5,
    parameter int TIM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_en,
    input  logic              prot,
    input  logic              cmd_rd,
    input  logic              cmd_pg,
    input  logic              cmd_clr,
    input  logic [IDX_W-1:0]  blk_idx,
    input  logic [TIM_W-1:0]  rd_tim,
    input  logic [TIM_W-1:0]  wr_tim,
    input  logic [FUSE_W-1:0] fuse_word,
    output logic [IDX_W-1:0]  lat_idx,
    output logic [FUSE_W-1:0] rd_data,
    output logic              rd_busy,
    output logic              pg_busy,
    output logic              standby,
    output logic              rd_done,
    output logic              rd_acc,
    output logic              pg_acc
);

    op_e              op_q;
    logic [TIM_W-1:0] cnt_q;
    logic             last;

    // a zero timing value still gives one busy cycle
    function automatic logic [TIM_W-1:0] run_len(input logic [TIM_W-1:0] t);
        return (t == '0) ? TIM_W'(1) : t;
    endfunction

    assign standby = mod_en && (op_q == OP_IDLE);
    assign rd_acc  = cmd_rd && standby;
    assign pg_acc  = cmd_pg && !cmd_rd && standby && !prot;
    assign last    = (op_q != OP_IDLE) && (cnt_q == TIM_W'(1));
    assign rd_busy = (op_q == OP_READ);
    assign pg_busy = (op_q == OP_PROG);

    // operation state and duration counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_IDLE;
            cnt_q   <= '0;
            lat_idx <= '0;
        end else if (rd_acc) begin
            op_q    <= OP_READ;
            cnt_q   <= run_len(rd_tim);
            lat_idx <= blk_idx;
        end else if (pg_acc) begin
            op_q    <= OP_PROG;
            cnt_q   <= run_len(wr_tim);
        end else if (last) begin
            op_q    <= OP_IDLE;
            cnt_q   <= '0;
        end else if (op_q != OP_IDLE) begin
            cnt_q   <= cnt_q - TIM_W'(1);
        end
    end

    // sticky completion flag; a finishing read beats a clear
    always_ff @(posedge clk) begin
        if (!rst_n)                        rd_done <= 1'b0;
        else if (last && op_q == OP_READ)  rd_done <= 1'b1;
        else if (cmd_clr)                  rd_done <= 1'b0;
    end

    // read data capture at completion
    always_ff @(posedge clk) begin
        if (!rst_n)                        rd_data <= '0;
        else if (last && op_q == OP_READ)  rd_data <= fuse_word;
    end

endmodule

// File: rtl/fuse_read_ctrl.sv
// Top of the fuse word reader: register slave, sequencer and fuse array.
// Assumes a single bus master issuing at most one access per cycle,
// and a protect strap that is stable while commands are issued.
module fuse_read_ctrl
    import fuse_ctrl_pkg::*;
#(
    parameter int          AW         = 6,
    parameter int          DATA_W     = 32,
    parameter int          FUSE_W     = 16,
    parameter int          N_BLK      = 32,
    parameter int          TIM_W      = 8,
    parameter int          RD_TIM_RST = 4,
    parameter int          WR_TIM_RST = 8,
    parameter logic [31:0] SEED       = 32'h0000_C3A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_en,
    input  logic              prot_strap,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int IDX_W = $clog2(N_BLK);

    logic [IDX_W-1:0]  blk_idx, lat_idx;
    logic [TIM_W-1:0]  rd_tim, wr_tim;
    logic [FUSE_W-1:0] fuse_word, rd_data;
    logic              cmd_rd, cmd_pg, cmd_clr;
    logic              rd_busy, pg_busy, standby, rd_done, rd_acc, pg_acc;

    fuse_regs #(
        .AW(AW), .DATA_W(DATA_W), .FUSE_W(FUSE_W), .IDX_W(IDX_W),
        .TIM_W(TIM_W), .RD_TIM_RST(RD_TIM_RST), .WR_TIM_RST(WR_TIM_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .st_pg_busy(pg_busy), .st_rd_busy(rd_busy), .st_idle(standby),
        .st_prot(prot_strap), .st_done(rd_done), .rd_word(rd_data),
        .blk_idx(blk_idx), .rd_tim(rd_tim), .wr_tim(wr_tim),
        .cmd_rd(cmd_rd), .cmd_pg(cmd_pg), .cmd_clr(cmd_clr)
    );

    fuse_seq #(
        .FUSE_W(FUSE_W), .IDX_W(IDX_W), .TIM_W(TIM_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .prot(prot_strap),
        .cmd_rd(cmd_rd), .cmd_pg(cmd_pg), .cmd_clr(cmd_clr),
        .blk_idx(blk_idx), .rd_tim(rd_tim), .wr_tim(wr_tim),
        .fuse_word(fuse_word), .lat_idx(lat_idx), .rd_data(rd_data),
        .rd_busy(rd_busy), .pg_busy(pg_busy), .standby(standby),
        .rd_done(rd_done), .rd_acc(rd_acc), .pg_acc(pg_acc)
    );

    fuse_rom #(
        .N_BLK(N_BLK), .FUSE_W(FUSE_W), .IDX_W(IDX_W), .SEED(SEED)
    ) u_rom (
        .sel(lat_idx), .word(fuse_word)
    );

endmodule

// File: rtl/fuse_read_ctrl_chk.sv
// Protocol checker for the fuse word reader, bound to the top.
// It observes the sequencer outputs and the command strobes.
module fuse_read_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic mod_en,
    input logic prot_strap,
    input logic rd_busy,
    input logic pg_busy,
    input logic standby,
    input logic rd_done,
    input logic rd_acc,
    input logic cmd_clr
);

    p_idle_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |-> !standby);

    p_start_goes_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> rd_busy && !standby);

    p_busy_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_busy && pg_busy));

    p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done && !cmd_clr |=> rd_done);

    p_done_with_busy_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_done) |-> $fell(rd_busy));

    p_protect_blocks_burn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prot_strap && !pg_busy |=> !pg_busy);

endmodule

bind fuse_read_ctrl fuse_read_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .prot_strap(prot_strap),
    .rd_busy(rd_busy), .pg_busy(pg_busy), .standby(standby),
    .rd_done(rd_done), .rd_acc(rd_acc), .cmd_clr(cmd_clr)
);

// File: tb/fuse_read_ctrl_tb.sv
`timescale 1ns/1ps
module fuse_read_ctrl_tb;

    localparam int AW = 6;
    localparam int ST = 'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mod_en = 1'b0;
    logic        prot_strap = 1'b0;
    logic [AW-1:0] bus_addr = AW'(ST);
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_chk = 0;
    int n_fail = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    fuse_read_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .prot_strap(prot_strap),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    // behavioural reference state
    int m_glb, m_wdat, m_deb, m_idx, m_rtim, m_wtim, m_rdata, m_done;
    int m_op, m_cnt, m_lidx;   // m_op: 0 idle, 1 read, 2 burn
    bit sb, crd, cpg, cclr, fin, wcmd;

    function automatic int fuse_ref(input int i);
        return ('hC3A5 ^ (i * 'h0811)) & 'hFFFF;
    endfunction

    function automatic int m_status();
        return ((m_op == 2) ? 1 : 0) | ((m_op == 1) ? 2 : 0)
             | ((mod_en && m_op == 0) ? 4 : 0) | (prot_strap ? 8 : 0)
             | (m_done ? 16 : 0);
    endfunction

    function automatic int m_read(input int a);
        case (a)
            'h00: return m_glb;
            'h04: return m_rdata;
            'h08: return m_wdat;
            'h0C: return m_idx;
            'h14: return m_status();
            'h20: return m_wtim;
            'h24: return m_rtim;
            'h28: return m_deb;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input int got, input int exp, input string req, input string what);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // reference model, advanced once per clock from the driven inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_glb = 0; m_wdat = 0; m_deb = 0; m_idx = 0; m_rtim = 4; m_wtim = 8;
            m_rdata = 0; m_done = 0; m_op = 0; m_cnt = 0; m_lidx = 0;
        end else begin
            sb   = mod_en && (m_op == 0);
            wcmd = bus_wr && (int'(bus_addr) == 'h10);
            crd  = wcmd && bus_wdata[1];
            cpg  = wcmd && bus_wdata[0] && !bus_wdata[1];
            cclr = wcmd && bus_wdata[2];
            fin  = (m_op != 0) && (m_cnt == 1);
            if (fin && m_op == 1) begin
                m_done = 1;
                m_rdata = fuse_ref(m_lidx);
            end else if (cclr) m_done = 0;
            if (crd && sb) begin
                m_op = 1; m_cnt = (m_rtim == 0) ? 1 : m_rtim; m_lidx = m_idx;
            end else if (cpg && sb && !prot_strap) begin
                m_op = 2; m_cnt = (m_wtim == 0) ? 1 : m_wtim;
            end else if (fin) begin
                m_op = 0; m_cnt = 0;
            end else if (m_op != 0) m_cnt = m_cnt - 1;
            if (bus_wr) begin
                case (int'(bus_addr))
                    'h00: m_glb  = bus_wdata & 'hFFFF;
                    'h08: m_wdat = bus_wdata & 'hFFFF;
                    'h0C: m_idx  = bus_wdata & 'h1F;
                    'h20: m_wtim = bus_wdata & 'hFF;
                    'h24: m_rtim = bus_wdata & 'hFF;
                    'h28: m_deb  = bus_wdata & 'hFFFF;
                    default: ;
                endcase
            end
        end
    end

    // every-cycle comparison of the addressed register against the model
    always @(negedge clk) begin
        if (rst_n) chk(int'(bus_rdata), m_read(int'(bus_addr)), cur_req, "model compare");
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input int a, input int d);
        bus_addr = AW'(a); bus_wr = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_addr = AW'(ST);
    endtask

    task automatic rd_expect(input int a, input int exp, input string req);
        bus_addr = AW'(a);
        @(negedge clk);
        chk(int'(bus_rdata), exp, req, $sformatf("read of 0x%0h", a));
        @(posedge clk); #1;
        bus_addr = AW'(ST);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R4 watchdog: got timeout expected end of sequence");
        summary();
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        // R1 reset values and enable-gated idle flag
        cur_req = "R1";
        rd_expect('h24, 4, "R1");
        rd_expect('h20, 8, "R1");
        rd_expect('h0C, 0, "R1");
        rd_expect('h04, 0, "R1");
        rd_expect('h00, 0, "R1");
        rd_expect(ST, 0, "R1");
        mod_en = 1'b1;
        rd_expect(ST, 4, "R1");
        // R2 index width
        cur_req = "R2";
        wr('h0C, 32'hFFFF_FFE7);
        rd_expect('h0C, 7, "R2");
        // R9 holes and unaligned offsets
        cur_req = "R9";
        rd_expect('h18, 0, "R9");
        wr('h18, 'hFFFF);
        rd_expect('h18, 0, "R9");
        rd_expect('h02, 0, "R9");
        rd_expect('h3C, 0, "R9");
        // R11 status is read-only, command reads zero
        cur_req = "R11";
        wr(ST, 32'hFFFF_FFFF);
        rd_expect(ST, 4, "R11");
        rd_expect('h10, 0, "R11");
        // R3 read ignored while disabled
        cur_req = "R3";
        mod_en = 1'b0;
        wr('h10, 2);
        cyc(3);
        rd_expect(ST, 0, "R3");
        mod_en = 1'b1;
        rd_expect(ST, 4, "R3");
        // R4 R5 default-length read of word 7
        cur_req = "R4";
        wr('h0C, 7);
        wr('h10, 2);
        rd_expect(ST, 2, "R4");
        cyc(2);
        rd_expect(ST, 2, "R4");
        rd_expect(ST, 'h14, "R4");
        cur_req = "R5";
        rd_expect('h04, fuse_ref(7), "R5");
        // R6 data read does not clear the flag; clear does
        cur_req = "R6";
        rd_expect('h04, fuse_ref(7), "R6");
        rd_expect(ST, 'h14, "R6");
        wr('h10, 4);
        rd_expect(ST, 4, "R6");
        // R4 zero timing value runs one cycle
        cur_req = "R4";
        wr('h24, 0);
        wr('h0C, 31);
        wr('h10, 2);
        rd_expect(ST, 2, "R4");
        rd_expect(ST, 'h14, "R4");
        rd_expect('h04, fuse_ref(31), "R5");
        // R6 clear coinciding with completion leaves the flag set
        cur_req = "R6";
        wr('h10, 4);
        wr('h24, 2);
        wr('h10, 2);
        cyc(1);
        wr('h10, 4);
        rd_expect(ST, 'h14, "R6");
        // R3 second command during a read is ignored
        cur_req = "R3";
        wr('h10, 4);
        wr('h24, 6);
        wr('h0C, 3);
        wr('h10, 2);
        wr('h0C, 9);
        wr('h10, 2);
        cyc(3);
        rd_expect(ST, 2, "R3");
        rd_expect(ST, 'h14, "R3");
        rd_expect('h04, fuse_ref(3), "R3");
        // R7 burn pulse, array untouched
        cur_req = "R7";
        wr('h10, 4);
        wr('h20, 5);
        wr('h10, 1);
        rd_expect(ST, 1, "R7");
        cyc(4);
        rd_expect(ST, 4, "R7");
        wr('h24, 1);
        wr('h10, 2);
        cyc(1);
        rd_expect('h04, fuse_ref(9), "R7");
        // R7 protect blocks burn
        wr('h10, 4);
        prot_strap = 1'b1;
        wr('h10, 1);
        rd_expect(ST, 'hC, "R7");
        prot_strap = 1'b0;
        // R7 read wins over burn in one write
        wr('h10, 3);
        rd_expect(ST, 2, "R7");
        cyc(1);
        // R10 enable drop does not abort a read
        cur_req = "R10";
        wr('h10, 4);
        wr('h24, 3);
        wr('h10, 2);
        mod_en = 1'b0;
        cyc(3);
        rd_expect(ST, 'h10, "R10");
        mod_en = 1'b1;
        // R5 every word with varied timing
        cur_req = "R5";
        for (int i = 0; i < 32; i++) begin
            wr('h24, i % 5);
            wr('h0C, i);
            wr('h10, 2);
            cyc(5);
            rd_expect('h04, fuse_ref(i), "R5");
            wr('h10, 4);
        end
        summary();
        $finish;
    end

endmodule